// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the master end of a shared parallel bus on which one group of lines carries first a byte address and then data. A local requester hands it a cycle type, a byte address, write data and a block count. The block runs the whole bus cycle. It first drives the address with its output enable and lets the lines settle for a set number of clocks. It then raises an address strobe, which stays high until the cycle ends. One or more data phases follow, each controlled by a read or write strobe and the slave's reply line.

Each data phase is a full four-phase handshake: the strobe goes up, the slave replies, the strobe goes down, and the master waits for the reply to drop. The master handles deskew by holding address or data stable on the lines before each strobe. It also times out any phase that stalls and ends the cycle with an error. Addresses that fall in the top device window of the address space raise a separate I/O select line for the whole cycle.

Read data is handed back one word per read phase. Write data is taken from the local side one word per write phase, and a pulse tells the requester when the current word has been consumed.

Top module: `mxb_master`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bus_oe`, `bus_as`, `bus_rds`, `bus_wrs` are low and `bus_out` is zero.
- R2: Every accepted cycle starts with exactly one address phase. `bus_out` carries the 22-bit request address, with `bus_oe` high, for exactly ASETUP clocks before `bus_as` rises. `bus_as` then stays high until the cycle ends.
- R3: `bus_io` is high throughout a cycle whose address has bits [21:13] all ones, and low throughout any other cycle.
- R4: In a read phase the master releases the lines (`bus_oe` low) and asserts `bus_rds`. The full 16-bit word on `bus_in` when the reply is seen is returned on `rd_data` with a one-clock `rd_valid`. No byte read exists.
- R5: In a write phase the data is on `bus_out[15:0]` with `bus_oe` high for at least DSETUP clocks before `bus_wrs` rises, and it stays unchanged while `bus_wrs` is high.
- R6: Byte writes (type 2, and the write half of type 4) put `wr_data[7:0]` on the lane chosen by address bit 0: bit 0 = 0 selects lines [7:0], bit 0 = 1 selects lines [15:8]. The other lane is zero and `bus_wbyte` is high with `bus_wrs`.
- R7: A strobe falls only after the reply has been seen high. No new strobe rises while the reply is still high.
- R8: Word read (type 0) and word write (type 1) with `req_len` = n perform n+1 data phases after a single address phase, and `bus_blk` is high when n > 0. For all other types `req_len` is ignored and no block indication is given.
- R9: Read-modify-write (type 3 word, type 4 byte) performs one read phase and then one write phase at the same address, with no second address phase. The read word is returned to the requester.
- R10: If a strobe is held for TMO clocks without a reply, the master drops all strobes and `bus_oe` and pulses `done` with `err` high. A reply that arrives in the last of those TMO clocks completes the phase normally.
- R11: A reply that never drops after a strobe falls also ends the cycle with `err` after TMO clocks.
- R12: Type codes 5 to 7 are rejected with a `done`/`err` pulse in the clock after acceptance, and no bus activity.
- R13: `busy` is high from acceptance until `done`. A `req_go` seen while busy is ignored.
- R14: `wd_used` pulses once each time a write word is taken from `wr_data`, one pulse per write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | Start a cycle (taken only while idle) |
| req_type | input | 3 | 0 read, 1 write, 2 byte write, 3 RMW, 4 byte RMW |
| req_addr | input | 22 | Byte address |
| req_len | input | LEN_W | Extra data words for block read/write |
| wr_data | input | 16 | Write word (byte in [7:0] for byte types) |
| busy | output | 1 | Cycle in progress |
| wd_used | output | 1 | Current write word taken; present the next |
| rd_valid | output | 1 | `rd_data` holds a fresh read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | Cycle finished (one clock) |
| err | output | 1 | Cycle ended in error, valid with `done` |
| bus_out | output | 22 | Multiplexed address/data lines, driven value |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| bus_in | input | 16 | Data lines as received |
| bus_as | output | 1 | Address strobe, held for the whole cycle |
| bus_rds | output | 1 | Read data strobe |
| bus_wrs | output | 1 | Write data strobe |
| bus_wbyte | output | 1 | Write phase carries one byte |
| bus_io | output | 1 | Cycle targets the device window |
| bus_blk | output | 1 | Multi-word block cycle |
| bus_rply | input | 1 | Slave reply |

## Verification
The functions that can fall in the same clock are arrival of the slave reply and expiry of the timeout counter. The bench reproduces this by setting its slave model's reply delay to exactly TMO-1 clocks after the strobe rises, and then to TMO clocks. The first case must end with no error and the correct word returned. The second case must end with `err` and the strobe must have been high for exactly TMO clocks. The remaining sweep covers every type, block length, reply delay and both address windows against a reference memory.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    typedef enum logic [2:0] {
        CYC_RD   = 3'd0,
        CYC_WR   = 3'd1,
        CYC_WRB  = 3'd2,
        CYC_RMW  = 3'd3,
        CYC_RMWB = 3'd4
    } cyc_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ASET, S_AHOLD, S_DSET, S_DWAIT, S_DRLS, S_FIN
    } st_e;
endpackage

// File: rtl/mxb_iodec.sv
module mxb_iodec #(
    parameter int AW      = 22,
    parameter int IO_BITS = 13
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    // device window = top 2**IO_BITS bytes of the address space
    assign hit = &addr[AW-1:IO_BITS];
endmodule

// File: rtl/mxb_lane.sv
module mxb_lane #(
    parameter int DW = 16
) (
    input  logic          byte_en,
    input  logic          a0,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] lanes
);
    localparam int HB = DW / 2;

    always_comb begin
        if (!byte_en)
            lanes = wd;
        else if (a0)
            lanes = {wd[HB-1:0], {HB{1'b0}}};
        else
            lanes = {{HB{1'b0}}, wd[HB-1:0]};
    end
endmodule

// File: rtl/mxb_tmo.sv
module mxb_tmo #(
    parameter int TMO = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expired
);
    localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == CW'(TMO - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mxb_master.sv
module mxb_master
    import mxb_pkg::*;
#(
    parameter int AW      = 22,
    parameter int DW      = 16,
    parameter int LEN_W   = 4,
    parameter int ASETUP  = 2,
    parameter int DSETUP  = 2,
    parameter int TMO     = 1024,
    parameter int IO_BITS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_go,
    input  logic [2:0]       req_type,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DW-1:0]    wr_data,
    output logic             busy,
    output logic             wd_used,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             err,
    output logic [AW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic [DW-1:0]    bus_in,
    output logic             bus_as,
    output logic             bus_rds,
    output logic             bus_wrs,
    output logic             bus_wbyte,
    output logic             bus_io,
    output logic             bus_blk,
    input  logic             bus_rply
);
    localparam int SMAX = (ASETUP > DSETUP) ? ASETUP : DSETUP;
    localparam int CW   = $clog2(SMAX + 1);

    typedef struct packed {
        st_e             st;
        logic [CW-1:0]   cnt;
        logic [LEN_W-1:0] left;
        cyc_e            typ;
        logic            a0;
        logic            wph;
        logic [AW-1:0]   out;
        logic            oe;
        logic            as;
        logic            rds;
        logic            wrs;
        logic            wbyte;
        logic            io;
        logic            blk;
        logic [DW-1:0]   rdat;
        logic            rvld;
        logic            wused;
        logic            done;
        logic            err;
    } regs_t;

    regs_t q, d;

    logic          io_hit;
    logic [DW-1:0] lane_data;
    logic          tmo_exp, tmo_run, tmo_clr;
    logic          is_byte, is_rmw;
    logic          go_data, fin_ok, abort;

    assign is_byte = (q.typ == CYC_WRB) || (q.typ == CYC_RMWB);
    assign is_rmw  = (q.typ == CYC_RMW) || (q.typ == CYC_RMWB);
    assign tmo_run = (q.st == S_DWAIT) || (q.st == S_DRLS);
    assign tmo_clr = (d.st != q.st);

    mxb_iodec #(.AW(AW), .IO_BITS(IO_BITS)) u_iodec (
        .addr (req_addr),
        .hit  (io_hit)
    );

    mxb_lane #(.DW(DW)) u_lane (
        .byte_en (is_byte),
        .a0      (q.a0),
        .wd      (wr_data),
        .lanes   (lane_data)
    );

    mxb_tmo #(.TMO(TMO)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .clr     (tmo_clr),
        .expired (tmo_exp)
    );

    always_comb begin
        d       = q;
        d.rvld  = 1'b0;
        d.wused = 1'b0;
        d.done  = 1'b0;
        go_data = 1'b0;
        fin_ok  = 1'b0;
        abort   = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (req_go) begin
                    if (req_type > 3'd4) begin
                        abort = 1'b1;
                    end else begin
                        d.st   = S_ASET;
                        d.typ  = cyc_e'(req_type);
                        d.a0   = req_addr[0];
                        d.out  = req_addr;
                        d.oe   = 1'b1;
                        d.io   = io_hit;
                        d.cnt  = '0;
                        d.err  = 1'b0;
                        d.wph  = (req_type == 3'd1) || (req_type == 3'd2);
                        if (req_type <= 3'd1) begin
                            d.left = req_len;
                            d.blk  = (req_len != '0);
                        end else begin
                            d.left = '0;
                            d.blk  = 1'b0;
                        end
                    end
                end
            end
            S_ASET: begin
                if (q.cnt == CW'(ASETUP - 1)) begin
                    d.st = S_AHOLD;
                    d.as = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            S_AHOLD: go_data = 1'b1;
            S_DSET: begin
                if (q.cnt == CW'(DSETUP - 1)) begin
                    d.st = S_DWAIT;
                    if (q.wph) begin
                        d.wrs   = 1'b1;
                        d.wbyte = is_byte;
                    end else begin
                        d.rds = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            S_DWAIT: begin
                // a reply in the final counted clock wins over expiry
                if (bus_rply) begin
                    d.st    = S_DRLS;
                    d.rds   = 1'b0;
                    d.wrs   = 1'b0;
                    d.wbyte = 1'b0;
                    if (!q.wph) begin
                        d.rdat = bus_in;
                        d.rvld = 1'b1;
                    end
                end else if (tmo_exp) begin
                    abort = 1'b1;
                end
            end
            S_DRLS: begin
                if (!bus_rply) begin
                    if (is_rmw && !q.wph) begin
                        d.wph   = 1'b1;
                        go_data = 1'b1;
                    end else if (q.left != '0) begin
                        d.left  = q.left - LEN_W'(1);
                        go_data = 1'b1;
                    end else begin
                        fin_ok = 1'b1;
                    end
                end else if (tmo_exp) begin
                    abort = 1'b1;
                end
            end
            S_FIN:   d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase

        if (go_data) begin
            d.st  = S_DSET;
            d.cnt = '0;
            if (d.wph) begin
                d.out   = {{(AW-DW){1'b0}}, lane_data};
                d.oe    = 1'b1;
                d.wused = 1'b1;
            end else begin
                d.out = '0;
                d.oe  = 1'b0;
            end
        end

        if (fin_ok || abort) begin
            d.st    = S_FIN;
            d.out   = '0;
            d.oe    = 1'b0;
            d.as    = 1'b0;
            d.rds   = 1'b0;
            d.wrs   = 1'b0;
            d.wbyte = 1'b0;
            d.io    = 1'b0;
            d.blk   = 1'b0;
            d.done  = 1'b1;
            d.err   = abort;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != S_IDLE);
    assign wd_used   = q.wused;
    assign rd_valid  = q.rvld;
    assign rd_data   = q.rdat;
    assign done      = q.done;
    assign err       = q.err;
    assign bus_out   = q.out;
    assign bus_oe    = q.oe;
    assign bus_as    = q.as;
    assign bus_rds   = q.rds;
    assign bus_wrs   = q.wrs;
    assign bus_wbyte = q.wbyte;
    assign bus_io    = q.io;
    assign bus_blk   = q.blk;
endmodule

// File: rtl/mxb_master_chk.sv
module mxb_master_chk #(
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_out,
    input logic          bus_oe,
    input logic          bus_as,
    input logic          bus_rds,
    input logic          bus_wrs,
    input logic          bus_wbyte,
    input logic          bus_io,
    input logic          done,
    input logic          rd_valid,
    input logic          wd_used
);
    a_r2_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as) |-> $past(bus_oe) && $stable(bus_out));

    a_r3_io_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io |-> (bus_as || bus_oe));

    a_r4_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rds |-> !bus_oe);

    a_r5_data_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wrs) |-> $past(bus_oe) && $stable(bus_out));

    a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wrs && $past(bus_wrs)) |-> $stable(bus_out));

    a_r6_byte_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wbyte |-> bus_wrs);

    a_r7_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rds || bus_wrs) |-> bus_as);

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rds && bus_wrs));

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_as && !bus_oe && !bus_rds && !bus_wrs);

    a_r14_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, rd_valid, wd_used}));
endmodule

bind mxb_master mxb_master_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .bus_as    (bus_as),
    .bus_rds   (bus_rds),
    .bus_wrs   (bus_wrs),
    .bus_wbyte (bus_wbyte),
    .bus_io    (bus_io),
    .done      (done),
    .rd_valid  (rd_valid),
    .wd_used   (wd_used)
);

// File: tb/mxb_master_tb.sv
`timescale 1ns/1ps
module mxb_master_tb;
    localparam int AW = 22, DW = 16, LW = 2, AS = 2, DS = 2, TMO = 24, IOB = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_go = 1'b0;
    logic [2:0]    req_type = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [DW-1:0] wr_data;
    logic          busy, wd_used, rd_valid, done, err;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_out;
    logic          bus_oe, bus_as, bus_rds, bus_wrs, bus_wbyte, bus_io, bus_blk;
    logic [DW-1:0] bus_in;
    logic          rply;

    mxb_master #(.AW(AW), .DW(DW), .LEN_W(LW), .ASETUP(AS), .DSETUP(DS),
                 .TMO(TMO), .IO_BITS(IOB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_type(req_type),
        .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
        .busy(busy), .wd_used(wd_used), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err(err), .bus_out(bus_out), .bus_oe(bus_oe),
        .bus_in(bus_in), .bus_as(bus_as), .bus_rds(bus_rds), .bus_wrs(bus_wrs),
        .bus_wbyte(bus_wbyte), .bus_io(bus_io), .bus_blk(bus_blk),
        .bus_rply(rply)
    );

    int n_chk = 0, n_fail = 0;

    function automatic logic [15:0] wseq(logic [15:0] b, int k);
        return b ^ (16'h1357 * 16'(k + 1));
    endfunction

    function automatic logic [15:0] minit(int i);
        return 16'h3C00 + 16'(i * 16'h0111);
    endfunction

    // stimulus-side state
    logic [15:0] wbase = '0;
    int          wu0 = 0, rv0 = 0;
    int          smode = 0, sdly = 0;
    logic [15:0] refm [16];

    // monitor / slave state (cumulative)
    int tot_as = 0, tot_rds = 0, tot_wrs = 0, tot_rv = 0, tot_wu = 0, tot_stc = 0;
    int tot_set = 0, tot_io = 0, tot_4p = 0, tot_blk = 0;
    int run_len = 0, prev_run = 0, swc = 0, pre_as = 0;
    logic        io_at_as = 0, wbyte_seen = 0;
    logic [15:0] lane_seen = '0;
    logic [15:0] rdbuf [8];
    logic [15:0] smem [16];
    logic [3:0]  sptr = '0;
    logic        sa0 = 1'b0;
    logic [AW-1:0] prev_out = '0;
    logic        prev_oe = 0, prev_as = 0, prev_rds = 0, prev_wrs = 0;

    assign wr_data = wseq(wbase, tot_wu - wu0);

    always @(negedge clk) begin
        if (!rst_n) begin
            rply = 1'b0;
            bus_in = '0;
            for (int i = 0; i < 16; i++) smem[i] = minit(i);
        end else begin
            if (bus_oe && prev_oe && bus_out == prev_out) run_len = run_len + 1;
            else if (bus_oe) run_len = 1;
            else run_len = 0;
            if (bus_as && !prev_as) begin
                tot_as++; pre_as = prev_run; io_at_as = bus_io;
                sptr = bus_out[4:1]; sa0 = bus_out[0];
            end
            if (bus_as && bus_io != io_at_as) tot_io++;
            if (bus_rds && !prev_rds) begin
                tot_rds++; if (rply) tot_4p++;
            end
            if (bus_wrs && !prev_wrs) begin
                tot_wrs++; if (rply) tot_4p++;
                if (prev_run < DS) tot_set++;
                lane_seen = bus_out[15:0]; wbyte_seen = bus_wbyte;
            end
            if (bus_rds || bus_wrs) tot_stc++;
            if (bus_blk) tot_blk++;
            if (rd_valid) begin
                if (tot_rv - rv0 < 8) rdbuf[tot_rv - rv0] = rd_data;
                tot_rv++;
            end
            if (wd_used) tot_wu++;
            // slave model
            if ((bus_rds || bus_wrs) && !rply && smode != 1) begin
                if (swc >= sdly) begin
                    rply = 1'b1; swc = 0;
                    if (bus_rds) bus_in = smem[sptr];
                    else if (bus_wbyte) begin
                        if (sa0) smem[sptr][15:8] = bus_out[15:8];
                        else     smem[sptr][7:0]  = bus_out[7:0];
                    end else smem[sptr] = bus_out[15:0];
                end else swc++;
            end else if (!bus_rds && !bus_wrs && rply && smode != 2) begin
                rply = 1'b0;
                if (bus_blk) sptr = sptr + 4'd1;
            end
            if (!bus_rds && !bus_wrs) swc = 0;
            prev_out = bus_out; prev_oe = bus_oe; prev_as = bus_as;
            prev_rds = bus_rds; prev_wrs = bus_wrs; prev_run = run_len;
        end
    end

    task automatic chk(input string tag, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(tag, act == exp, act, exp);
    endtask

    int s_as, s_rds, s_wrs, s_rv, s_wu, s_stc, s_set, s_io, s_4p, s_blk;

    task automatic run_txn(input logic [2:0] typ, input logic [AW-1:0] a,
                           input logic [LW-1:0] len, input logic [15:0] wb,
                           output logic e, output int k);
        @(negedge clk);
        s_as = tot_as; s_rds = tot_rds; s_wrs = tot_wrs; s_rv = tot_rv; s_wu = tot_wu;
        s_stc = tot_stc; s_set = tot_set; s_io = tot_io; s_4p = tot_4p; s_blk = tot_blk;
        wbase = wb; wu0 = tot_wu; rv0 = tot_rv;
        req_type = typ; req_addr = a; req_len = len; req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
        k = 0;
        while (!done && k < TMO * 40) begin
            @(negedge clk);
            k++;
        end
        if (!done) chk("R10 cycle never finished", 1'b0, 32'(k), 32'd0);
        e = err;
        @(negedge clk);
    endtask

    task automatic mem_cmp(input string tag);
        int bad = 0;
        for (int i = 0; i < 16; i++) if (smem[i] !== refm[i]) bad++;
        chk_eq(tag, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic e;
        int   k;
        for (int i = 0; i < 16; i++) refm[i] = minit(i);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk_eq("R1 busy", {31'd0, busy}, 32'd0);
        chk_eq("R1 strobes/oe/done", {28'd0, bus_oe, bus_as, bus_rds | bus_wrs, done}, 32'd0);
        chk_eq("R1 bus_out", 32'(bus_out), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep: type x length x reply delay x window
        for (int t = 0; t < 5; t++)
        for (int l = 0; l < 4; l++)
        for (int dl = 0; dl < 3; dl++)
        for (int w = 0; w < 2; w++) begin
            int off, a0, eff, nrd, nwr;
            logic [AW-1:0] a;
            logic [15:0] wb, exr [8];
            logic [7:0] bt;
            off = (t * 7 + l * 3 + dl * 5 + w) & 15;
            a0  = (t == 2 || t == 4) ? ((l + dl) & 1) : 0;
            a   = (w != 0 ? 22'h3FE000 : 22'h001000) | AW'(off << 1) | AW'(a0);
            wb  = 16'hA5C3 ^ 16'(t * 4099 + l * 257 + dl * 31 + w * 7);
            eff = (t <= 1) ? l : 0;
            nrd = 0; nwr = 0;
            bt  = wseq(wb, 0)[7:0];
            case (t)
                0: begin for (int j = 0; j <= eff; j++) exr[j] = refm[(off + j) & 15]; nrd = eff + 1; end
                1: begin for (int j = 0; j <= eff; j++) refm[(off + j) & 15] = wseq(wb, j); nwr = eff + 1; end
                2: begin if (a0 != 0) refm[off][15:8] = bt; else refm[off][7:0] = bt; nwr = 1; end
                3: begin exr[0] = refm[off]; refm[off] = wseq(wb, 0); nrd = 1; nwr = 1; end
                default: begin exr[0] = refm[off];
                    if (a0 != 0) refm[off][15:8] = bt; else refm[off][7:0] = bt;
                    nrd = 1; nwr = 1; end
            endcase
            sdly = dl; smode = 0;
            run_txn(3'(t), a, LW'(l), wb, e, k);
            chk_eq("R7 no error", {31'd0, e}, 32'd0);
            chk_eq("R2 one address phase", 32'(tot_as - s_as), 32'd1);
            chk_eq("R2 address setup clocks", 32'(pre_as), 32'(AS));
            chk_eq("R3 io select", {31'd0, io_at_as}, 32'(w));
            chk_eq("R3 io steady", 32'(tot_io - s_io), 32'd0);
            chk_eq("R4 read phases", 32'(tot_rds - s_rds), 32'(nrd));
            chk_eq("R8 write phases", 32'(tot_wrs - s_wrs), 32'(nwr));
            chk_eq("R4 read words returned", 32'(tot_rv - s_rv), 32'(nrd));
            for (int j = 0; j < nrd; j++) chk_eq("R4 read data", 32'(rdbuf[j]), 32'(exr[j]));
            chk_eq("R5 data settle", 32'(tot_set - s_set), 32'd0);
            chk_eq("R7 four-phase", 32'(tot_4p - s_4p), 32'd0);
            chk_eq("R8 block indication", {31'd0, (tot_blk - s_blk) > 0}, {31'd0, eff > 0});
            chk_eq("R14 wd_used pulses", 32'(tot_wu - s_wu), 32'(nwr));
            if (t == 2 || t == 4) begin
                chk_eq("R6 byte flag", {31'd0, wbyte_seen}, 32'd1);
                chk_eq("R6 lane", 32'(lane_seen), a0 != 0 ? {16'd0, bt, 8'h00} : {24'd0, bt});
            end else if (nwr > 0) begin
                chk_eq("R6 word flag", {31'd0, wbyte_seen}, 32'd0);
            end
            if (t >= 3) chk_eq("R9 rmw single address", 32'(tot_as - s_as), 32'd1);
            mem_cmp("R9 memory contents");
        end

        // R3 window boundary
        sdly = 0; smode = 0;
        run_txn(3'd0, 22'h3FDFFE, '0, 16'h0, e, k);
        chk_eq("R3 just below window", {31'd0, io_at_as}, 32'd0);

        // R10 no reply on read
        smode = 1;
        run_txn(3'd0, 22'h000020, '0, 16'h0, e, k);
        chk_eq("R10 timeout err", {31'd0, e}, 32'd1);
        chk_eq("R10 strobe held clocks", 32'(tot_stc - s_stc), 32'(TMO));
        chk_eq("R10 no read word", 32'(tot_rv - s_rv), 32'd0);
        chk_eq("R10 lines quiet", {29'd0, bus_oe, bus_as, bus_rds | bus_wrs}, 32'd0);
        // R10 no reply on write leaves memory intact
        run_txn(3'd1, 22'h000022, '0, 16'h7777, e, k);
        chk_eq("R10 write timeout err", {31'd0, e}, 32'd1);
        mem_cmp("R10 memory untouched");

        // R10 reply in the last allowed clock vs one later
        smode = 0; sdly = TMO - 1;
        run_txn(3'd0, 22'h000004, '0, 16'h0, e, k);
        chk_eq("R10 last-clock reply ok", {31'd0, e}, 32'd0);
        chk_eq("R10 last-clock data", 32'(rdbuf[0]), 32'(refm[2]));
        sdly = TMO;
        run_txn(3'd0, 22'h000004, '0, 16'h0, e, k);
        chk_eq("R10 late reply err", {31'd0, e}, 32'd1);
        chk_eq("R10 late strobe clocks", 32'(tot_stc - s_stc), 32'(TMO));
        repeat (TMO + 4) @(negedge clk);

        // R11 reply stuck high
        smode = 2; sdly = 0;
        run_txn(3'd0, 22'h000006, '0, 16'h0, e, k);
        chk_eq("R11 stuck reply err", {31'd0, e}, 32'd1);
        smode = 0;
        repeat (3) @(negedge clk);

        // R12 illegal codes
        for (int c = 5; c < 8; c++) begin
            run_txn(3'(c), 22'h000008, '0, 16'h0, e, k);
            chk_eq("R12 illegal err", {31'd0, e}, 32'd1);
            chk_eq("R12 immediate", 32'(k), 32'd0);
            chk_eq("R12 no bus cycle", 32'(tot_as - s_as), 32'd0);
        end

        // R13 request while busy is ignored
        sdly = 2;
        @(negedge clk);
        s_as = tot_as; s_wrs = tot_wrs;
        req_type = 3'd0; req_addr = 22'h00000A; req_len = '0; req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R13 busy during cycle", {31'd0, busy}, 32'd1);
        req_type = 3'd1; req_addr = 22'h00001C; req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
        k = 0;
        while (!done && k < 200) begin @(negedge clk); k++; end
        repeat (8) @(negedge clk);
        chk_eq("R13 single cycle", 32'(tot_as - s_as), 32'd1);
        chk_eq("R13 no write issued", 32'(tot_wrs - s_wrs), 32'd0);
        chk_eq("R13 idle after", {31'd0, busy}, 32'd0);
        mem_cmp("R13 memory untouched");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule